// File: doc/BRIEF.md
# Interrupt Source Masking and Routing Bank

This block gathers up to 32 level-sensitive interrupt sources and merges them with requests raised by software. It applies a per-source enable mask and steers each surviving request to one of two processor lines: a normal interrupt or a fast interrupt. Software programs it over a simple single-cycle register port with address, write strobe, write data, a privilege flag and combinational read data.

Enables and software requests each have a set address and a separate clear address, and both use write-one semantics. A driver can therefore mask or acknowledge a single source without a read-modify-write. A protect bit limits register writes to privileged accesses. A test-control bit removes the hardware inputs so that software requests alone reach the status words. Four identification byte registers let software find out which controller it is talking to.

Top module: `irq_route_bank`

## Requirements
- R1: After reset the select, enable, soft-request, protect and test-control registers read 0, and `irq_o` and `fiq_o` are low.
- R2: The raw status word at 0x08 equals the hardware inputs ORed with the soft-request bits. Reading it, or any other status word, changes nothing.
- R3: The normal status word at 0x00 equals raw AND enable AND NOT select. The fast status word at 0x04 equals raw AND enable AND select. A select bit of 1 routes its source to the fast output.
- R4: Writing to 0x10 sets every enable bit that is 1 in the write data. Writing to 0x14 clears every enable bit that is 1 in the write data. Zero bits leave the mask unchanged in both cases. The enable mask reads back at 0x10.
- R5: Writing to 0x18 sets every soft-request bit that is 1 in the write data. Writing to 0x1C clears every soft-request bit that is 1 in the write data. The soft bits read back at 0x18. Acknowledging a source means clearing its enable bit and its soft bit, and this drops its request.
- R6: `irq_o` is the OR of the normal status word and `fiq_o` is the OR of the fast status word. Both are registered, so they follow the status one clock later.
- R7: Protect bit 0 is at 0x20. While it is 1, any write with `bus_priv` low is ignored. This includes writes to the protect register itself.
- R8: Reads of the clear addresses 0x14 and 0x1C return 0. Reads of an unmapped address also return 0.
- R9: Addresses 0xFE0, 0xFE4, 0xFE8 and 0xFEC each return one byte of `PERIPH_ID` in bits 7:0, least significant byte first. The default identification word is 0x00041190, whose bits 19:12 hold the vendor code 0x41.
- R10: Test-control bit 0 is at 0x300. While it is 1, the hardware inputs are excluded from raw status, so only soft requests contribute.
- R11: The select register at 0x0C is a full read/write word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NSRC | Level-sensitive hardware interrupt inputs |
| bus_addr | input | AW | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_priv | input | 1 | Access is privileged |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_o | output | 1 | Normal interrupt request, active high |
| fiq_o | output | 1 | Fast interrupt request, active high |

## Verification
Read data is combinational. The status words and register readbacks are therefore due in the same cycle that the address is presented. A written register is due from the clock edge that ends its write cycle. The two interrupt lines settle one edge after any change to inputs, enables, selects or soft bits.

The driver presents each stimulus just after a rising edge and queues the expected item in a scoreboard. For line checks, it first lets one more rising edge pass. The monitor compares every queued item at the falling edge that follows, so it never samples at an active edge.

// File: rtl/irq_route_bank.sv
module irq_route_bank #(
  parameter int          NSRC      = 32,
  parameter int          AW        = 12,
  parameter logic [31:0] PERIPH_ID = 32'h0004_1190
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_we,
  input  logic            bus_priv,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            irq_o,
  output logic            fiq_o
);
  localparam logic [AW-1:0] A_IRQST   = AW'('h000);
  localparam logic [AW-1:0] A_FIQST   = AW'('h004);
  localparam logic [AW-1:0] A_RAWST   = AW'('h008);
  localparam logic [AW-1:0] A_SEL     = AW'('h00C);
  localparam logic [AW-1:0] A_ENSET   = AW'('h010);
  localparam logic [AW-1:0] A_ENCLR   = AW'('h014);
  localparam logic [AW-1:0] A_SOFTSET = AW'('h018);
  localparam logic [AW-1:0] A_SOFTCLR = AW'('h01C);
  localparam logic [AW-1:0] A_PROT    = AW'('h020);
  localparam logic [AW-1:0] A_TEST    = AW'('h300);
  localparam logic [AW-1:0] A_ID0     = AW'('hFE0);

  logic [NSRC-1:0] sel_q, en_q, soft_q;
  logic            prot_q, test_q;

  wire             wr_ok    = bus_we && (!prot_q || bus_priv);
  wire [NSRC-1:0]  wd       = bus_wdata[NSRC-1:0];
  wire [NSRC-1:0]  raw      = (test_q ? '0 : src_i) | soft_q;
  wire [NSRC-1:0]  irq_stat = raw & en_q & ~sel_q;
  wire [NSRC-1:0]  fiq_stat = raw & en_q & sel_q;
  wire             id_hit   = (bus_addr[AW-1:4] == A_ID0[AW-1:4]) && (bus_addr[1:0] == 2'b00);
  wire [31:0]      id_shift = PERIPH_ID >> {bus_addr[3:2], 3'b000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      en_q   <= '0;
      soft_q <= '0;
      prot_q <= 1'b0;
      test_q <= 1'b0;
      irq_o  <= 1'b0;
      fiq_o  <= 1'b0;
    end else begin
      irq_o <= |irq_stat;
      fiq_o <= |fiq_stat;
      if (wr_ok) begin
        case (bus_addr)
          A_SEL:     sel_q  <= wd;
          A_ENSET:   en_q   <= en_q | wd;
          A_ENCLR:   en_q   <= en_q & ~wd;
          A_SOFTSET: soft_q <= soft_q | wd;
          A_SOFTCLR: soft_q <= soft_q & ~wd;
          A_PROT:    prot_q <= bus_wdata[0];
          A_TEST:    test_q <= bus_wdata[0];
          default:   ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_IRQST:   bus_rdata[NSRC-1:0] = irq_stat;
      A_FIQST:   bus_rdata[NSRC-1:0] = fiq_stat;
      A_RAWST:   bus_rdata[NSRC-1:0] = raw;
      A_SEL:     bus_rdata[NSRC-1:0] = sel_q;
      A_ENSET:   bus_rdata[NSRC-1:0] = en_q;
      A_SOFTSET: bus_rdata[NSRC-1:0] = soft_q;
      A_PROT:    bus_rdata[0]        = prot_q;
      A_TEST:    bus_rdata[0]        = test_q;
      default:   if (id_hit) bus_rdata[7:0] = id_shift[7:0];
    endcase
  end

  p_reset_quiet_r1: assert property (@(posedge clk) $rose(rst_n) |-> !irq_o && !fiq_o);

  p_no_mask_no_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |=> (!irq_o && !fiq_o));

  p_enset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (bus_priv || !prot_q) && bus_addr == A_ENSET)
      |=> ((en_q & $past(wd)) == $past(wd)));

  p_enclr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (bus_priv || !prot_q) && bus_addr == A_ENCLR)
      |=> ((en_q & $past(wd)) == '0));

  p_softclr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (bus_priv || !prot_q) && bus_addr == A_SOFTCLR)
      |=> ((soft_q & $past(wd)) == '0));

  p_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_q && bus_we && !bus_priv)
      |=> ($stable(en_q) && $stable(sel_q) && $stable(soft_q) && $stable(prot_q) && $stable(test_q)));

  p_clr_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_ENCLR || bus_addr == A_SOFTCLR) |-> (bus_rdata == 32'h0));
endmodule

// File: tb/tb_irq_route_bank.sv
module tb_irq_route_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_i = '0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic        bus_priv = 1'b1;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, fiq_o;

  irq_route_bank dut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_priv(bus_priv), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .fiq_o(fiq_o));

  always #5 clk = ~clk;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = q.pop_front();
      act = (it.kind == 0) ? bus_rdata : (it.kind == 1) ? {31'b0, irq_o} : {31'b0, fiq_o};
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic p);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_priv = p; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0; bus_priv = 1'b1;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    bus_addr = a;
    q.push_back('{0, e, tag});
  endtask

  task automatic out(input int kind, input logic e, input string tag);
    @(posedge clk); #1;
    q.push_back('{kind, {31'b0, e}, tag});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    rd(12'h000, 0, "R1 irq status at reset");
    rd(12'h004, 0, "R1 fiq status at reset");
    rd(12'h008, 0, "R1 raw status at reset");
    rd(12'h00C, 0, "R1 select at reset");
    rd(12'h010, 0, "R1 enable at reset");
    rd(12'h018, 0, "R1 soft at reset");
    rd(12'h020, 0, "R1 protect at reset");
    rd(12'h300, 0, "R1 test ctrl at reset");
    out(1, 1'b0, "R1 irq_o at reset");
    out(2, 1'b0, "R1 fiq_o at reset");

    rd(12'hFE0, 32'h90, "R9 id byte0");
    rd(12'hFE4, 32'h11, "R9 id byte1");
    rd(12'hFE8, 32'h04, "R9 id byte2");
    rd(12'hFEC, 32'h00, "R9 id byte3");

    @(posedge clk); #1 src_i = 32'h0000_00F0;
    rd(12'h008, 32'h0000_00F0, "R2 raw follows inputs");
    rd(12'h008, 32'h0000_00F0, "R2 raw re-read unchanged");
    rd(12'h000, 0, "R3 irq status masked");
    out(1, 1'b0, "R6 irq_o low while masked");

    wr(12'h010, 32'h0000_0030, 1'b1);
    rd(12'h010, 32'h0000_0030, "R4 enable set readback");
    rd(12'h000, 32'h0000_0030, "R3 irq status enabled");
    out(1, 1'b1, "R6 irq_o high");
    out(2, 1'b0, "R6 fiq_o low");

    wr(12'h00C, 32'h0000_0020, 1'b1);
    rd(12'h00C, 32'h0000_0020, "R11 select readback");
    rd(12'h000, 32'h0000_0010, "R3 irq status after select");
    rd(12'h004, 32'h0000_0020, "R3 fiq status after select");
    out(2, 1'b1, "R6 fiq_o high");

    wr(12'h014, 32'h0000_0010, 1'b1);
    rd(12'h010, 32'h0000_0020, "R4 enable clear one bit");
    out(1, 1'b0, "R6 irq_o drops after clear");
    wr(12'h010, 32'h0, 1'b1);
    wr(12'h014, 32'h0, 1'b1);
    rd(12'h010, 32'h0000_0020, "R4 zero writes no effect");

    wr(12'h018, 32'h8000_0001, 1'b1);
    rd(12'h018, 32'h8000_0001, "R5 soft readback");
    rd(12'h008, 32'h8000_00F1, "R2 raw includes soft");
    wr(12'h010, 32'h8000_0000, 1'b1);
    rd(12'h000, 32'h8000_0000, "R3 soft request routed normal");
    wr(12'h01C, 32'h8000_0000, 1'b1);
    rd(12'h018, 32'h0000_0001, "R5 soft clear one bit");
    rd(12'h000, 0, "R5 soft cleared status");

    rd(12'h014, 0, "R8 enable-clear reads zero");
    rd(12'h01C, 0, "R8 soft-clear reads zero");
    rd(12'h040, 0, "R8 unmapped reads zero");

    wr(12'h300, 32'h1, 1'b1);
    rd(12'h300, 32'h1, "R10 test ctrl readback");
    rd(12'h008, 32'h0000_0001, "R10 raw excludes inputs");
    out(2, 1'b0, "R10 fiq_o low without inputs");
    wr(12'h300, 32'h0, 1'b1);
    rd(12'h008, 32'h0000_00F1, "R10 inputs return");

    wr(12'h020, 32'h1, 1'b1);
    rd(12'h020, 32'h1, "R7 protect readback");
    wr(12'h010, 32'h0000_FFFF, 1'b0);
    rd(12'h010, 32'h8000_0020, "R7 unprivileged write ignored");
    wr(12'h020, 32'h0, 1'b0);
    rd(12'h020, 32'h1, "R7 protect self-locked");
    wr(12'h010, 32'h0000_0001, 1'b1);
    rd(12'h010, 32'h8000_0021, "R7 privileged write accepted");
    wr(12'h020, 32'h0, 1'b1);
    rd(12'h020, 32'h0, "R7 protect cleared");

    @(posedge clk); #1 src_i = 32'h0;
    out(1, 1'b1, "R6 irq_o from soft bit0");
    wr(12'h014, 32'h1, 1'b1);
    wr(12'h01C, 32'h1, 1'b1);
    rd(12'h008, 0, "R5 ack clears soft");
    out(1, 1'b0, "R5 irq_o low after ack");

    repeat (2) @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule